// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Qualification

This block holds two phase-frequency comparators, one for each synthesizer loop. Both are clocked by the reference-oscillator clock. Each comparator watches the rising edges of a reference pulse `fr` and a divided-VCO pulse `fp`. It drives a pair of charge-pump enables, `up` and `dn`. When both enables are low, the pump output floats.

Each comparator takes its own polarity bit, which swaps the two enables to suit the sense of the VCO and loop filter. At the end of every comparison both enables are driven high for a short fixed window, so a locked loop never sits in a dead zone.

The phase error is measured in oscillator cycles: it is the number of cycles between the earlier and the later rising edge. A digital filter per channel uses that count to decide lock. It drops lock at once when the error reaches an unlock window. It regains lock only after a run of consecutive comparisons whose error lies within a narrower lock window.

A sleep input per channel turns that channel's pump off and makes it report locked. After sleep, the first comparison has its one-sided pulse clamped, so the VCO does not take a large step on wake-up.

A single shared output pin carries one of two things. The first is the combined lock, which is high only when every channel is locked or asleep. The second, when the monitor is enabled, is one of the four raw comparator inputs.

Top module: `dual_pd_lock`

## Requirements
- R1: With `pol_i[c]=1`, when the rising edge of `fr` leads the rising edge of `fp` by k cycles, `pump_up_o[c]` alone is high for exactly k cycles. When `fp` leads by k cycles, `pump_dn_o[c]` alone is high for k cycles.
- R2: With `pol_i[c]=0`, the two enables are swapped: when `fr` leads by k cycles, `pump_dn_o[c]` alone is high for k cycles, and when `fp` leads, `pump_up_o[c]` alone is high.
- R3: Every comparison ends with both enables high together for exactly DZ_CYC cycles. When the two edges arrive in the same cycle, no one-sided pulse appears.
- R4: `lock_o[c]` falls when the one-sided error reaches UNLOCK_CYC cycles. An error above LOCK_CYC but below UNLOCK_CYC leaves the lock state unchanged.
- R5: `lock_o[c]` rises only after QUAL_CNT consecutive comparisons with an error of at most LOCK_CYC. A comparison with a larger error restarts the run.
- R6: With `mon_en_i=0`, `pin_o` is 1 only when every channel is locked or asleep, and 0 otherwise.
- R7: With `mon_en_i=1`, `pin_o` follows one raw input. `mon_sel_i[0]` selects the channel (0 or 1) and `mon_sel_i[1]` selects `fr` (0) or `fp` (1).
- R8: While `sleep_i[c]=1`, both enables of channel c are low, `lock_o[c]` is 1, and input edges have no effect on the pump.
- R9: On the first comparison after `sleep_i[c]` falls, the one-sided pulse lasts at most CLAMP_CYC cycles. Later comparisons are not clamped.
- R10: After reset, all enables are low, `lock_o` is 0 and, with the monitor off, `pin_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fr_i | input | 2 | Reference pulse per channel |
| fp_i | input | 2 | Divided-VCO pulse per channel |
| pol_i | input | 2 | Per-channel polarity, 1 = up when fr leads |
| sleep_i | input | 2 | Per-channel power-save |
| mon_en_i | input | 1 | 1 routes a monitor signal to pin_o |
| mon_sel_i | input | 2 | Monitor choice: bit0 channel, bit1 fp/fr |
| pump_up_o | output | 2 | Charge-pump source enable per channel |
| pump_dn_o | output | 2 | Charge-pump sink enable per channel |
| lock_o | output | 2 | Per-channel lock (high when asleep) |
| pin_o | output | 1 | Shared lock/monitor output |

## Verification
The bench builds the block with these parameters:
- DZ_CYC=2, so every dead-zone window is distinct from a single-cycle glitch.
- CLAMP_CYC=3, so a six-cycle lead after wake-up shows the clamp cutting the pulse in half.
- LOCK_CYC=1 and UNLOCK_CYC=4, which leave a middle band of errors (2 and 3 cycles). Those errors must neither lock nor unlock the channel.
- QUAL_CNT=3, which lets the bench prove that two good comparisons are not enough to lock.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int NCH = 2;

  // mon_sel bit0 picks the channel, bit1 picks fp over fr
  typedef enum logic [1:0] {
    MON_FR0 = 2'b00,
    MON_FR1 = 2'b01,
    MON_FP0 = 2'b10,
    MON_FP1 = 2'b11
  } mon_sel_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pd_core.sv
module pd_core #(
  parameter int DZ_CYC    = 2,
  parameter int CLAMP_CYC = 4,
  parameter int CW        = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fr_i,
  input  logic          fp_i,
  input  logic          pol_i,
  input  logic          sleep_i,
  output logic          up_o,
  output logic          dn_o,
  output logic          cmp_o,
  output logic [CW-1:0] err_o
);
  localparam int DZW = $clog2(DZ_CYC + 1);
  localparam logic [DZW-1:0] DZ_LAST = DZW'(DZ_CYC - 1);
  localparam logic [CW-1:0]  ERR_MAX = {CW{1'b1}};
  localparam logic [CW-1:0]  CLAMP_V = CW'(CLAMP_CYC);

  logic fr_d, fp_d, up_q, dn_q, fresh_q;
  logic [DZW-1:0] dz_q;
  logic [CW-1:0]  err_q;
  logic fr_rise, fp_rise, both, one_side, mask;

  assign fr_rise  = fr_i & ~fr_d;
  assign fp_rise  = fp_i & ~fp_d;
  assign both     = up_q & dn_q;
  assign one_side = up_q ^ dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_d    <= 1'b0;
      fp_d    <= 1'b0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      dz_q    <= '0;
      err_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      fr_d <= fr_i;
      fp_d <= fp_i;
      if (sleep_i) begin
        up_q    <= 1'b0;
        dn_q    <= 1'b0;
        dz_q    <= '0;
        err_q   <= '0;
        fresh_q <= 1'b1;
      end else begin
        if (both) begin
          if (dz_q == '0) fresh_q <= 1'b0;
          if (dz_q == DZ_LAST) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
            dz_q <= '0;
          end else begin
            dz_q <= dz_q + 1'b1;
          end
        end else begin
          up_q <= up_q | fr_rise;
          dn_q <= dn_q | fp_rise;
        end
        if (!up_q && !dn_q)                 err_q <= '0;
        else if (one_side && err_q != ERR_MAX) err_q <= err_q + 1'b1;
      end
    end
  end

  // limit the first one-sided pulse after wake-up
  assign mask  = fresh_q & one_side & (err_q >= CLAMP_V);

  assign up_o  = (pol_i ? up_q : dn_q) & ~mask & ~sleep_i;
  assign dn_o  = (pol_i ? dn_q : up_q) & ~mask & ~sleep_i;
  assign cmp_o = both & (dz_q == '0) & ~sleep_i;
  assign err_o = err_q;
endmodule

// File: rtl/lock_filt.sv
module lock_filt #(
  parameter int LOCK_CYC   = 1,
  parameter int UNLOCK_CYC = 3,
  parameter int QUAL_CNT   = 3,
  parameter int CW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_i,
  input  logic          cmp_i,
  input  logic [CW-1:0] err_i,
  output logic          lock_o
);
  localparam int QW = $clog2(QUAL_CNT + 1);
  localparam logic [QW-1:0] QUAL_V   = QW'(QUAL_CNT);
  localparam logic [CW-1:0] LOCK_V   = CW'(LOCK_CYC);
  localparam logic [CW-1:0] UNLOCK_V = CW'(UNLOCK_CYC);

  logic          locked_q;
  logic [QW-1:0] good_q, good_n;

  assign good_n = (good_q == QUAL_V) ? good_q : good_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      good_q   <= '0;
    end else if (sleep_i || err_i >= UNLOCK_V) begin
      locked_q <= 1'b0;
      good_q   <= '0;
    end else if (cmp_i) begin
      if (err_i <= LOCK_V) begin
        good_q <= good_n;
        if (good_n == QUAL_V) locked_q <= 1'b1;
      end else begin
        good_q <= '0;
      end
    end
  end

  assign lock_o = locked_q | sleep_i;
endmodule

// File: rtl/out_sel.sv
module out_sel
  import pd_pkg::*;
(
  input  logic           mon_en_i,
  input  logic [1:0]     mon_sel_i,
  input  logic [NCH-1:0] lock_i,
  input  logic [NCH-1:0] fr_i,
  input  logic [NCH-1:0] fp_i,
  output logic           pin_o
);
  logic mon;

  always_comb begin
    unique case (mon_sel_e'(mon_sel_i))
      MON_FR0: mon = fr_i[0];
      MON_FR1: mon = fr_i[1];
      MON_FP0: mon = fp_i[0];
      MON_FP1: mon = fp_i[1];
      default: mon = 1'b0;
    endcase
  end

  assign pin_o = mon_en_i ? mon : &lock_i;
endmodule

// File: rtl/dual_pd_lock.sv
module dual_pd_lock
  import pd_pkg::*;
#(
  parameter int DZ_CYC     = 2,
  parameter int CLAMP_CYC  = 4,
  parameter int LOCK_CYC   = 1,
  parameter int UNLOCK_CYC = 3,
  parameter int QUAL_CNT   = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] fr_i,
  input  logic [NCH-1:0] fp_i,
  input  logic [NCH-1:0] pol_i,
  input  logic [NCH-1:0] sleep_i,
  input  logic           mon_en_i,
  input  logic [1:0]     mon_sel_i,
  output logic [NCH-1:0] pump_up_o,
  output logic [NCH-1:0] pump_dn_o,
  output logic [NCH-1:0] lock_o,
  output logic           pin_o
);
  localparam int ERR_TOP = max2(UNLOCK_CYC, CLAMP_CYC);
  localparam int CW      = $clog2(ERR_TOP + 2);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          cmp;
    logic [CW-1:0] err;

    pd_core #(.DZ_CYC(DZ_CYC), .CLAMP_CYC(CLAMP_CYC), .CW(CW)) u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fr_i   (fr_i[c]),
      .fp_i   (fp_i[c]),
      .pol_i  (pol_i[c]),
      .sleep_i(sleep_i[c]),
      .up_o   (pump_up_o[c]),
      .dn_o   (pump_dn_o[c]),
      .cmp_o  (cmp),
      .err_o  (err)
    );

    lock_filt #(.LOCK_CYC(LOCK_CYC), .UNLOCK_CYC(UNLOCK_CYC),
                .QUAL_CNT(QUAL_CNT), .CW(CW)) u_lock (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sleep_i(sleep_i[c]),
      .cmp_i  (cmp),
      .err_i  (err),
      .lock_o (lock_o[c])
    );
  end

  out_sel u_sel (
    .mon_en_i (mon_en_i),
    .mon_sel_i(mon_sel_i),
    .lock_i   (lock_o),
    .fr_i     (fr_i),
    .fp_i     (fp_i),
    .pin_o    (pin_o)
  );
endmodule

// File: rtl/dual_pd_lock_chk.sv
module dual_pd_lock_chk
  import pd_pkg::*;
#(
  parameter int DZ_CYC = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] sleep_i,
  input logic           mon_en_i,
  input logic [NCH-1:0] pump_up_o,
  input logic [NCH-1:0] pump_dn_o,
  input logic [NCH-1:0] lock_o,
  input logic           pin_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R8
    sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_i[c] |-> (!pump_up_o[c] && !pump_dn_o[c] && lock_o[c]));

    // R9
    wake_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sleep_i[c]) |-> (!pump_up_o[c] && !pump_dn_o[c]));

    // R5
    lock_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(lock_o[c]) && !sleep_i[c] && !$past(sleep_i[c]))
        |-> $past(pump_up_o[c] && pump_dn_o[c]));

    if (DZ_CYC > 1) begin : g_dz
      // R3
      dead_zone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(pump_up_o[c] && pump_dn_o[c]) && !sleep_i[c])
          |=> ((pump_up_o[c] && pump_dn_o[c]) || sleep_i[c]));
    end
  end

  // R6
  combine_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&sleep_i && !mon_en_i) |-> pin_o);
endmodule

bind dual_pd_lock dual_pd_lock_chk #(.DZ_CYC(DZ_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sleep_i  (sleep_i),
  .mon_en_i (mon_en_i),
  .pump_up_o(pump_up_o),
  .pump_dn_o(pump_dn_o),
  .lock_o   (lock_o),
  .pin_o    (pin_o)
);

// File: tb/sim_dual_pd_lock.sv
`timescale 1ns/1ps
module sim_dual_pd_lock;
  localparam int DZ = 2, CLAMP = 3, LOCKW = 1, UNLOCKW = 4, QUAL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fr = '0, fp = '0, pol = 2'b11, sleep = '0, mon_sel = '0;
  logic mon_en = 1'b0;
  logic [1:0] up, dn, lk;
  logic pin;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_pd_lock #(.DZ_CYC(DZ), .CLAMP_CYC(CLAMP), .LOCK_CYC(LOCKW),
                 .UNLOCK_CYC(UNLOCKW), .QUAL_CNT(QUAL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fr_i(fr), .fp_i(fp), .pol_i(pol),
    .sleep_i(sleep), .mon_en_i(mon_en), .mon_sel_i(mon_sel),
    .pump_up_o(up), .pump_dn_o(dn), .lock_o(lk), .pin_o(pin));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // lead > 0: fr edge first; lead < 0: fp edge first
  task automatic compare(input int ch, input int lead,
                         output int hi_only, output int lo_only, output int both);
    int tfr = (lead >= 0) ? 0 : -lead;
    int tfp = (lead >= 0) ? lead : 0;
    int span = ((lead >= 0) ? lead : -lead) + DZ + 4;
    hi_only = 0; lo_only = 0; both = 0;
    for (int t = 0; t <= span; t++) begin
      @(negedge clk);
      if (t > 0) begin
        if (up[ch] && !dn[ch]) hi_only++;
        if (dn[ch] && !up[ch]) lo_only++;
        if (up[ch] && dn[ch])  both++;
      end
      fr[ch] = (t == tfr);
      fp[ch] = (t == tfp);
    end
    fr[ch] = 1'b0; fp[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10", "pump_up", int'(up), 0);
    chk("R10", "pump_dn", int'(dn), 0);
    chk("R10", "lock", int'(lk), 0);
    chk("R10", "pin", int'(pin), 0);
  endtask

  task automatic t_polarity;
    int h, l, b;
    pol = 2'b11;
    compare(0, 3, h, l, b);
    chk("R1", "fr lead up", h, 3); chk("R1", "fr lead dn", l, 0); chk("R3", "dz", b, DZ);
    compare(0, -2, h, l, b);
    chk("R1", "fp lead dn", l, 2); chk("R1", "fp lead up", h, 0);
    pol = 2'b00;
    compare(0, 3, h, l, b);
    chk("R2", "inv fr lead dn", l, 3); chk("R2", "inv fr lead up", h, 0);
    compare(1, -2, h, l, b);
    chk("R2", "inv fp lead up ch1", h, 2); chk("R2", "inv fp lead dn ch1", l, 0);
    pol = 2'b11;
  endtask

  task automatic t_aligned;
    int h, l, b;
    compare(0, 0, h, l, b);
    chk("R3", "aligned one-sided", h + l, 0);
    chk("R3", "aligned dz", b, DZ);
  endtask

  task automatic t_lock;
    int h, l, b;
    compare(0, 3, h, l, b);   // restarts run
    compare(0, 0, h, l, b);
    compare(0, 1, h, l, b);
    chk("R5", "two good not locked", int'(lk[0]), 0);
    compare(0, 0, h, l, b);
    chk("R5", "third good locked", int'(lk[0]), 1);
    chk("R6", "pin ch1 unlocked", int'(pin), 0);
    sleep[1] = 1'b1; @(negedge clk);
    chk("R6", "pin ch1 asleep", int'(pin), 1);
  endtask

  task automatic t_unlock;
    int h, l, b;
    compare(0, 3, h, l, b);
    chk("R4", "mid error keeps lock", int'(lk[0]), 1);
    compare(0, -UNLOCKW, h, l, b);
    chk("R4", "large error unlocks", int'(lk[0]), 0);
    chk("R6", "pin after unlock", int'(pin), 0);
  endtask

  task automatic t_monitor;
    sleep = 2'b11; mon_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      mon_sel = 2'(s);
      {fp, fr} = 4'b0001 << s;   // only the selected input high
      @(negedge clk);
      chk("R7", $sformatf("sel %0d high", s), int'(pin), 1);
      {fp, fr} = ~(4'b0001 << s);
      @(negedge clk);
      chk("R7", $sformatf("sel %0d low", s), int'(pin), 0);
    end
    fr = '0; fp = '0; mon_en = 1'b0;
    @(negedge clk);
    chk("R6", "both asleep", int'(pin), 1);
    sleep = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_sleep_clamp;
    int h, l, b;
    sleep[0] = 1'b1;
    compare(0, 3, h, l, b);
    chk("R8", "asleep pump activity", h + l + b, 0);
    chk("R8", "asleep lock", int'(lk[0]), 1);
    sleep[0] = 1'b0;
    @(negedge clk);
    compare(0, 6, h, l, b);
    chk("R9", "first pulse clamped", h, CLAMP);
    chk("R9", "first dz", b, DZ);
    compare(0, 6, h, l, b);
    chk("R9", "second pulse full", h, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_polarity();
    t_aligned();
    t_lock();
    t_unlock();
    sleep[1] = 1'b0;
    t_monitor();
    t_sleep_clamp();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule